// File: doc/BRIEF.md
# Queued SPI Master

This block is an SPI master that works through a short list of transfers on its own. Software loads up to sixteen entries into three small on-chip stores through one pointer register and one data port: a command word per entry, the word to send per entry, and (after the run) the word received per entry. It then writes the index of the last entry to run and sets a start bit. The engine walks entries from index 0 to that last index, shifts each word out MSB first while capturing the returning line, stores what it received at the same index, and raises a completion flag.

Each command word picks which of four select outputs is driven active for that entry, whether the entry shifts eight bits or the width programmed in the mode register, and whether the selects stay active into the following entry. The mode register sets clock polarity, clock phase, the programmable width and an 8-bit divider; one half period of SCK lasts `baud` system clocks. The idle level of all selects is programmable, and the active level is its complement.

Top module: `qspi_queue_master`

Register offsets (`reg_addr`): 0 mode, 1 control, 2 queue configuration, 3 status, 4 pointer, 5 data port.

## Requirements
- R1: After reset every select output sits at its idle level 1 (`spi_cs` = 4'hF), `spi_sck` is 0, `queue_done` is 0 and control bit 0 (busy) reads 0.
- R2: The pointer register holds a region in bits [9:8] (0 command, 1 transmit, 2 receive) and an entry index in bits [3:0]; every read or write of the data port moves the index up by one, so consecutive accesses cover consecutive entries and the pointer reads back the advanced index.
- R3: Writing 1 to control bit 0 runs entries 0 up to the last index in queue configuration bits [3:0], in order; each entry sends the low bits of its transmit word MSB first and the word received for it is readable at the same index of the receive region, right aligned.
- R4: With command bit 1 set an entry shifts the number of bits in mode bits [11:8] (value 0 means 16); with it clear the entry shifts 8 bits.
- R5: Every SCK half period lasts `baud` system clocks, where `baud` is mode bits [7:0]; values 0 and 1 behave as 2.
- R6: Mode bit 13 is clock polarity (SCK idle level) and bit 12 is clock phase: with phase 0 data is captured on the first edge of each bit and changed on the second, with phase 1 it is changed on the first and captured on the second.
- R7: During an entry, select output i is driven to the complement of the idle level (queue configuration bit 8) when command bit 2+i is set; the other selects stay at the idle level.
- R8: Command bit 0 keeps the entry's selects active straight into the next entry; when it is clear all selects return to idle for at least one half period before the next entry; after the last entry all selects are idle.
- R9: When the last entry finishes, status bit 0 and `queue_done` go to 1 and busy clears by itself; writing 1 to status bit 0 clears the flag and writing 0 leaves it set.
- R10: A start is ignored while mode bit 14 (master enable) is 0: busy stays 0, no select is driven and the flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the pointer on the data port) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Select outputs |
| queue_done | output | 1 | Completion flag |

## Verification
The bench plays an SPI slave that answers each entry with its own word and a monitor that rebuilds every shifted word bit by bit, in all four polarity and phase combinations. It aims at the divider clamp (a design that ignored it would run SCK at one clock per half period, or hang with a zero divider), the width field value 0 meaning 16 (a design that got it wrong would shift no bits or wrap the entry), and the phase 1 case where the first bit must not be shifted away before its first edge (a design that got it wrong would lose the MSB and return words off by one bit). It also runs a full sixteen-entry queue, mixes held and released selects so that a missing or spurious idle gap shows up, flips the select idle level, and tests that a write of 0 to the flag does not clear it and that a start without master enable does nothing.

// File: rtl/qspi_queue_master.sv
module qspi_queue_master #(
  parameter int DEPTH = 16,
  parameter int NCS   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     reg_addr,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [15:0]    reg_wdata,
  output logic [15:0]    reg_rdata,
  output logic           spi_sck,
  output logic           spi_mosi,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs,
  output logic           queue_done
);

  localparam int IW = $clog2(DEPTH);
  localparam logic [2:0] A_MODE = 3'd0, A_CTRL = 3'd1, A_QCFG = 3'd2,
                         A_STAT = 3'd3, A_PTR  = 3'd4, A_DATA = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_RUN, S_GAP} st_t;

  logic [15:0] cmd_mem [DEPTH];
  logic [15:0] tx_mem  [DEPTH];
  logic [15:0] rx_mem  [DEPTH];

  logic [15:0]    mode_q;
  logic [IW-1:0]  end_q;
  logic           idle_q;
  logic [IW-1:0]  ptr_idx;
  logic [1:0]     ptr_rgn;
  logic           done_q;

  st_t            st;
  logic [IW-1:0]  idx;
  logic [7:0]     div_cnt;
  logic [4:0]     edge_cnt;
  logic [4:0]     nbits;
  logic           hold_q;
  logic [NCS-1:0] sel_q;
  logic [15:0]    tx_sr, rx_sr;
  logic           sck_q, cs_on;

  wire        cpha     = mode_q[12];
  wire        cpol     = mode_q[13];
  wire        mst_en   = mode_q[14];
  wire [7:0]  baud_eff = (mode_q[7:0] < 8'd2) ? 8'd2 : mode_q[7:0];
  wire [4:0]  mode_n   = (mode_q[11:8] == 4'd0) ? 5'd16 : {1'b0, mode_q[11:8]};
  wire        tick     = (div_cnt == 8'd0);
  wire        busy     = (st != S_IDLE);
  wire        start    = reg_wr && reg_addr == A_CTRL && reg_wdata[0] && mst_en && !busy;
  wire        data_acc = (reg_wr || reg_rd) && reg_addr == A_DATA;
  wire        finish   = (st == S_GAP) && tick && (idx == end_q);
  wire        samp     = (edge_cnt[0] == cpha);
  wire [5:0]  last_e   = {nbits, 1'b0} - 6'd1;
  wire        last     = ({1'b0, edge_cnt} == last_e);
  wire [15:0] rx_shift = {rx_sr[14:0], spi_miso};
  wire [15:0] cw       = cmd_mem[idx];
  wire [4:0]  n_next   = cw[1] ? mode_n : 5'd8;

  assign spi_sck    = sck_q ^ cpol;
  assign spi_mosi   = tx_sr[15];
  assign queue_done = done_q;

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign spi_cs[i] = (cs_on && sel_q[i]) ? ~idle_q : idle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      end_q   <= '0;
      idle_q  <= 1'b1;
      ptr_idx <= '0;
      ptr_rgn <= '0;
      done_q  <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_MODE: mode_q <= reg_wdata;
          A_QCFG: begin
            end_q  <= reg_wdata[IW-1:0];
            idle_q <= reg_wdata[8];
          end
          A_PTR: begin
            ptr_idx <= reg_wdata[IW-1:0];
            ptr_rgn <= reg_wdata[9:8];
          end
          default: ;
        endcase
      end
      if (data_acc) ptr_idx <= ptr_idx + 1'b1;
      if (finish) done_q <= 1'b1;
      else if (reg_wr && reg_addr == A_STAT && reg_wdata[0]) done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (reg_wr && reg_addr == A_DATA) begin
      if (ptr_rgn == 2'd0) cmd_mem[ptr_idx] <= reg_wdata;
      if (ptr_rgn == 2'd1) tx_mem[ptr_idx]  <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_RUN && tick && last) rx_mem[idx] <= samp ? rx_shift : rx_sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      nbits    <= 5'd8;
      hold_q   <= 1'b0;
      sel_q    <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      sck_q    <= 1'b0;
      cs_on    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          idx <= '0;
          st  <= S_SETUP;
        end
        S_SETUP: begin
          nbits    <= n_next;
          tx_sr    <= tx_mem[idx] << (5'd16 - n_next);
          rx_sr    <= '0;
          sel_q    <= cw[2 +: NCS];
          hold_q   <= cw[0];
          cs_on    <= 1'b1;
          div_cnt  <= baud_eff - 8'd1;
          edge_cnt <= '0;
          st       <= S_RUN;
        end
        S_RUN: begin
          if (tick) begin
            sck_q   <= ~sck_q;
            div_cnt <= baud_eff - 8'd1;
            if (samp) rx_sr <= rx_shift;
            else if (!(cpha && edge_cnt == 5'd0)) tx_sr <= tx_sr << 1;
            if (last) begin
              st <= S_GAP;
              if (!hold_q || idx == end_q) cs_on <= 1'b0;
            end else begin
              edge_cnt <= edge_cnt + 5'd1;
            end
          end else begin
            div_cnt <= div_cnt - 8'd1;
          end
        end
        S_GAP: begin
          if (tick) begin
            if (idx == end_q) st <= S_IDLE;
            else begin
              idx <= idx + 1'b1;
              st  <= S_SETUP;
            end
          end else begin
            div_cnt <= div_cnt - 8'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE: reg_rdata = mode_q;
      A_CTRL: reg_rdata = {15'd0, busy};
      A_QCFG: begin
        reg_rdata[IW-1:0] = end_q;
        reg_rdata[8]      = idle_q;
      end
      A_STAT: reg_rdata = {15'd0, done_q};
      A_PTR: begin
        reg_rdata[IW-1:0] = ptr_idx;
        reg_rdata[9:8]    = ptr_rgn;
      end
      A_DATA: begin
        case (ptr_rgn)
          2'd0:    reg_rdata = cmd_mem[ptr_idx];
          2'd1:    reg_rdata = tx_mem[ptr_idx];
          2'd2:    reg_rdata = rx_mem[ptr_idx];
          default: reg_rdata = '0;
        endcase
      end
      default: ;
    endcase
  end

  a_r3_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> (idx <= end_q));

  a_r5_sck_waits_divider: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !tick) |=> $stable(spi_sck));

  a_r6_sck_rests_at_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (spi_sck == cpol));

  a_r8_selects_idle_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (spi_cs == {NCS{idle_q}}));

  a_r9_flag_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(st) == S_GAP && st == S_IDLE));

  a_r10_no_start_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !mst_en) |=> (st == S_IDLE));

endmodule

// File: tb/qspi_queue_master_bench.sv
module qspi_queue_master_bench;

  localparam logic [2:0] A_MODE = 3'd0, A_CTRL = 3'd1, A_QCFG = 3'd2,
                         A_STAT = 3'd3, A_PTR  = 3'd4, A_DATA = 3'd5;

  typedef struct {
    logic [15:0] tx;
    int          n;
    logic [3:0]  mask;
    logic [15:0] reply;
    bit          gap;
  } item_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [3:0]  spi_cs;
  logic        queue_done;

  int errors = 0, checks = 0;

  qspi_queue_master u_qspi_queue_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs(spi_cs), .queue_done(queue_done));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // scoreboard and slave model
  item_t       exp_q[$];
  item_t       cur;
  bit          have_cur = 0, first_edge = 0, saw_idle = 1;
  bit          cfg_pol = 0, cfg_pha = 0, cfg_idle = 1;
  int          cfg_baud = 2;
  int          lead_cnt = 0, trail_cnt = 0, since = 0, per_err = 0;
  logic        last_sck = 1'b0;
  logic [15:0] cap = '0;
  logic [3:0]  cs_seen = '0;

  function automatic logic [15:0] nmask(input int n);
    return 16'((17'd1 << n) - 17'd1);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      since++;
      if (have_cur && spi_sck != last_sck) begin
        if (!first_edge && since != cfg_baud) per_err++;
        first_edge = 0;
        since = 0;
        if (spi_sck != cfg_pol) begin
          if (lead_cnt == 0) cs_seen = spi_cs;
          if (!cfg_pha) cap = {cap[14:0], spi_mosi};
          lead_cnt++;
        end else begin
          if (cfg_pha) cap = {cap[14:0], spi_mosi};
          trail_cnt++;
          if (trail_cnt == cur.n) begin
            automatic logic [3:0] ecs;
            for (int i = 0; i < 4; i++) ecs[i] = cur.mask[i] ? ~cfg_idle : cfg_idle;
            chk((cap & nmask(cur.n)) == (cur.tx & nmask(cur.n)), "R3/R4/R6 mosi word",
                cap & nmask(cur.n), cur.tx & nmask(cur.n));
            chk(cs_seen == ecs, "R7 select levels", cs_seen, ecs);
            chk(saw_idle == cur.gap, "R8 idle gap before entry", saw_idle, cur.gap);
            chk(per_err == 0, "R5 half period", per_err, 0);
            have_cur = 0;
            saw_idle = 0;
          end
        end
      end
      last_sck = spi_sck;
      if (spi_cs == {4{cfg_idle}}) saw_idle = 1;
      if (!have_cur && exp_q.size() > 0) begin
        cur = exp_q.pop_front();
        have_cur = 1; first_edge = 1; lead_cnt = 0; trail_cnt = 0; per_err = 0; cap = '0;
      end
      if (have_cur) begin
        automatic int k = cfg_pha ? lead_cnt - 1 : trail_cnt;
        spi_miso = (k >= 0 && k < cur.n) ? cur.reply[cur.n - 1 - k] : 1'b0;
      end else spi_miso = 1'b0;
    end
  end

  logic [15:0] cmdw [16];
  logic [15:0] txw  [16];
  logic [15:0] rep  [16];

  task automatic run_q(input int cnt, input bit pol, input bit pha, input logic [7:0] baud,
                       input logic [3:0] bits, input bit idl);
    logic [15:0] d;
    int          nn [16];
    int          guard;
    cfg_pol = pol; cfg_pha = pha; cfg_idle = idl;
    cfg_baud = (baud < 2) ? 2 : int'(baud);
    wr(A_MODE, {1'b0, 1'b1, pol, pha, bits, baud});
    wr(A_QCFG, (16'(idl) << 8) | 16'(cnt - 1));
    wr(A_PTR, 16'h0000);
    for (int i = 0; i < cnt; i++) wr(A_DATA, cmdw[i]);
    wr(A_PTR, 16'h0100);
    for (int i = 0; i < cnt; i++) wr(A_DATA, txw[i]);
    for (int i = 0; i < cnt; i++) begin
      automatic item_t it;
      nn[i] = cmdw[i][1] ? ((bits == 4'd0) ? 16 : int'(bits)) : 8;
      it.tx = txw[i]; it.n = nn[i]; it.mask = cmdw[i][5:2]; it.reply = rep[i];
      it.gap = (i == 0) ? 1'b1 : !cmdw[i-1][0];
      exp_q.push_back(it);
    end
    wr(A_CTRL, 16'h0001);
    rd(A_CTRL, d);
    chk(d[0] == 1'b1, "R9 busy while running", d, 1);
    guard = 0;
    while (!queue_done && guard < 40000) begin @(negedge clk); guard++; end
    chk(queue_done == 1'b1, "R9 flag raised", queue_done, 1);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0 && !have_cur, "R3 all entries shifted", exp_q.size(), 0);
    chk(spi_cs == {4{idl}}, "R8 selects idle after last entry", spi_cs, {4{idl}});
    chk(spi_sck == pol, "R6 sck idle level", spi_sck, pol);
    rd(A_CTRL, d);
    chk(d[0] == 1'b0, "R9 busy self-clears", d, 0);
    wr(A_PTR, 16'h0200);
    for (int i = 0; i < cnt; i++) begin
      rd(A_DATA, d);
      chk(d == (rep[i] & nmask(nn[i])), "R3 received word", d, rep[i] & nmask(nn[i]));
    end
    wr(A_STAT, 16'h0000);
    rd(A_STAT, d);
    chk(d[0] == 1'b1, "R9 write 0 keeps flag", d, 1);
    wr(A_STAT, 16'h0001);
    rd(A_STAT, d);
    chk(d[0] == 1'b0 && queue_done == 1'b0, "R9 write 1 clears flag", d, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(spi_cs == 4'hF, "R1 selects idle", spi_cs, 4'hF);
    chk(spi_sck == 1'b0, "R1 sck low", spi_sck, 0);
    chk(queue_done == 1'b0, "R1 flag clear", queue_done, 0);
    rd(A_CTRL, d);
    chk(d[0] == 1'b0, "R1 not busy", d, 0);

    // R2 pointer auto-increment
    wr(A_PTR, 16'h0100);
    wr(A_DATA, 16'hA1B2); wr(A_DATA, 16'h0C3D); wr(A_DATA, 16'h7E0F);
    rd(A_PTR, d);
    chk(d == 16'h0103, "R2 pointer advanced by writes", d, 16'h0103);
    wr(A_PTR, 16'h0100);
    rd(A_DATA, d); chk(d == 16'hA1B2, "R2 readback entry 0", d, 16'hA1B2);
    rd(A_DATA, d); chk(d == 16'h0C3D, "R2 readback entry 1", d, 16'h0C3D);
    rd(A_DATA, d); chk(d == 16'h7E0F, "R2 readback entry 2", d, 16'h7E0F);
    rd(A_PTR, d);
    chk(d == 16'h0103, "R2 pointer advanced by reads", d, 16'h0103);

    // R10 start without master enable
    wr(A_MODE, 16'h0002);
    wr(A_CTRL, 16'h0001);
    repeat (40) @(negedge clk);
    rd(A_CTRL, d);
    chk(d[0] == 1'b0, "R10 busy stays clear", d, 0);
    chk(spi_cs == 4'hF && queue_done == 1'b0, "R10 no selects, no flag", {spi_cs, queue_done}, 5'h1E);

    // mode 0, divider 2, 8-bit entries, held then released selects
    cmdw[0] = 16'h0005; txw[0] = 16'h00A5; rep[0] = 16'h003C;
    cmdw[1] = 16'h000C; txw[1] = 16'h0081; rep[1] = 16'h00F0;
    cmdw[2] = 16'h0010; txw[2] = 16'h007E; rep[2] = 16'h0099;
    run_q(3, 1'b0, 1'b0, 8'd2, 4'd0, 1'b1);

    // mode 3, divider 5, 12-bit entries
    cmdw[0] = 16'h0022; txw[0] = 16'h0ABC; rep[0] = 16'h0F0F;
    cmdw[1] = 16'h0007; txw[1] = 16'h0123; rep[1] = 16'h0801;
    cmdw[2] = 16'h0012; txw[2] = 16'hF999; rep[2] = 16'h0555;
    cmdw[3] = 16'h0008; txw[3] = 16'h00C3; rep[3] = 16'h00A6;
    run_q(4, 1'b1, 1'b1, 8'd5, 4'd12, 1'b1);

    // mode 1, divider 0 clamped to 2, width field 0 = 16 bits, full queue
    for (int i = 0; i < 16; i++) begin
      cmdw[i] = 16'(((i % 15) + 1) << 2) | 16'h0002 | 16'(i[0]);
      txw[i]  = 16'h8001 ^ 16'(i * 16'h1357);
      rep[i]  = 16'hC003 ^ 16'(i * 16'h0F21);
    end
    run_q(16, 1'b0, 1'b1, 8'd0, 4'd0, 1'b1);

    // mode 2, divider 3, idle level 0, single 5-bit entry
    cmdw[0] = 16'h0026; txw[0] = 16'h0013; rep[0] = 16'h000A;
    run_q(1, 1'b1, 1'b0, 8'd3, 4'd5, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule